// File: doc/BRIEF.md
# Per-Bank Locking Round-Robin Crossbar

This block sits between a set of requesting ports and a set of bank machines. Every port presents a command (valid, write flag, address). The bank index is pulled out of each address, and every bank owns a round-robin arbiter that picks one port among those currently aiming at it. The picked port's address and write flag are routed to that bank, and the bank's ready is routed back to the port.

A bank machine raises its lock while it still holds a transaction for the port it granted. While a bank's lock is high, its arbiter freezes, and no other bank may grant that same port. Write-ready and read-valid acknowledgements from a bank are sent to the port that the bank grants in the cycle of the pulse. They arrive after two fixed delays, each set by its own parameter, so that they line up with the data path outside the block.

Top module: `bank_lock_xbar`

## Requirements
- R1: The bank index of a port is the BANK_W-bit field of its address starting at bit BANK_LSB when MAP is MAP_LOW (default: bits [5:4] of a 16-bit address, 4 banks), and the top BANK_W address bits when MAP is MAP_HIGH.
- R2: A port is eligible at a bank only when its valid is high and its bank index equals that bank's number.
- R3: A port is not eligible at a bank while a different bank's arbiter grants it with that other bank's lock high.
- R4: When a bank's lock is low, its arbiter moves on the clock edge to the first eligible port in the order grant+1, grant+2, ... wrapping round to the current grant. It keeps its grant when no port is eligible.
- R5: While a bank's lock is high, its arbiter's grant does not change.
- R6: A bank's b_valid is high exactly when its granted port is eligible there. Its b_addr and b_we carry that port's address and write flag.
- R7: A port's p_ready equals the b_ready of the bank whose valid command comes from that port, and is 0 when no bank drives a valid command from it.
- R8: A b_wr_ack pulse at a bank appears on p_wr_ack of the port that the bank grants in the pulse cycle, WR_LAT clock edges later (default 2).
- R9: A b_rd_ack pulse at a bank appears on p_rd_ack of the port that the bank grants in the pulse cycle, RD_LAT clock edges later (default 3).
- R10: After reset every arbiter grants port 0, and no bank valid or port acknowledgement is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p_valid | input | NP | Command valid per port |
| p_we | input | NP | Write flag per port (1 = write) |
| p_addr | input | NP*AW | Address per port, port 0 in the low bits |
| p_ready | output | NP | Command accepted per port |
| p_wr_ack | output | NP | Delayed write-ready per port |
| p_rd_ack | output | NP | Delayed read-valid per port |
| b_valid | output | NB | Command valid per bank |
| b_we | output | NB | Write flag per bank |
| b_addr | output | NB*AW | Address per bank, bank 0 in the low bits |
| b_ready | input | NB | Bank accepts its command |
| b_lock | input | NB | Bank holds a transaction for its granted port |
| b_wr_ack | input | NB | Write-ready pulse from each bank |
| b_rd_ack | input | NB | Read-valid pulse from each bank |

## Verification
Some properties are checked on every cycle. A port is never ready without being valid. Each bank's command carries an address that decodes to that bank. A locked arbiter keeps its grant. No bank drives a command from a port that another locked bank holds. No acknowledgement leaves the delay lines before their latency has passed since reset. Other behaviour can only be shown by the bench's scenarios: the exact rotation order of grants, the ready routing under partial bank readiness, the release of an excluded port once a lock drops, and the routing of each acknowledgement to the right port at the right edge.

// File: rtl/xbar_pkg.sv
// Shared definitions for the bank crossbar.
// Assumes addresses no wider than 64 bits.
package xbar_pkg;

    typedef enum logic [0:0] {
        MAP_LOW  = 1'b0,   // bank field at a fixed low offset
        MAP_HIGH = 1'b1    // bank field in the top address bits
    } map_e;

    // Extract the bank field from an address under the chosen mapping.
    function automatic int unsigned bank_field(input logic [63:0] addr,
                                               input int aw, input int bw,
                                               input int lsb, input map_e mode);
        int pos;
        logic [63:0] sh;
        pos = (mode == MAP_HIGH) ? (aw - bw) : lsb;
        sh  = (addr >> pos) & ((64'd1 << bw) - 64'd1);
        return int'(sh[31:0]);
    endfunction

endpackage

// File: rtl/xbar_bank_decode.sv
// Per-port bank index decoder.
// Assumes the bank field lies fully inside the address.
module xbar_bank_decode #(
    parameter int              NP       = 3,
    parameter int              AW       = 16,
    parameter int              BANK_W   = 2,
    parameter int              BANK_LSB = 4,
    parameter xbar_pkg::map_e  MAP      = xbar_pkg::MAP_LOW
) (
    input  logic [NP*AW-1:0]     addr,
    output logic [NP*BANK_W-1:0] bank_idx
);
    // One decoder per port.
    for (genvar p = 0; p < NP; p++) begin : g_port
        assign bank_idx[p*BANK_W +: BANK_W] =
            BANK_W'(xbar_pkg::bank_field(64'(addr[p*AW +: AW]), AW, BANK_W, BANK_LSB, MAP));
    end
endmodule

// File: rtl/xbar_rr_arb.sv
// Round-robin arbiter for one bank with a freeze input.
// Assumes elig is already filtered for bank match and cross-bank locks.
module xbar_rr_arb #(
    parameter int NP    = 3,
    parameter int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    elig,
    input  logic             lock,
    output logic [IDX_W-1:0] grant,
    output logic             active
);
    logic [IDX_W-1:0] nxt;

    // Search eligible ports starting after the current grant.
    always_comb begin
        logic found;
        found = 1'b0;
        nxt   = grant;
        for (int k = 1; k <= NP; k++) begin
            if (!found && elig[(int'(grant) + k) % NP]) begin
                nxt   = IDX_W'((int'(grant) + k) % NP);
                found = 1'b1;
            end
        end
    end

    // Hold the grant under lock, otherwise rotate.
    always_ff @(posedge clk) begin
        if (!rst_n)     grant <= '0;
        else if (!lock) grant <= nxt;
    end

    // The granted port is currently eligible.
    assign active = elig[grant];
endmodule

// File: rtl/xbar_ack_delay.sv
// Fixed-latency shift line for per-port acknowledgement pulses.
// The one-hot port vector carries the destination index along with the pulse.
module xbar_ack_delay #(
    parameter int W   = 3,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (LAT == 0) begin : g_wire
        assign dout = din;
    end else begin : g_pipe
        logic [W-1:0] st [LAT];
        // Shift the pulse vector one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < LAT; k++) st[k] <= '0;
            end else begin
                st[0] <= din;
                for (int k = 1; k < LAT; k++) st[k] <= st[k-1];
            end
        end
        assign dout = st[LAT-1];
    end
endmodule

// File: rtl/bank_lock_xbar.sv
// Crossbar from NP ports to NB bank machines.
// One round-robin arbiter per bank. A bank's lock freezes its arbiter and
// hides its granted port from every other bank. Acknowledgements are routed
// to the granting port after fixed delays.
module bank_lock_xbar #(
    parameter int              NP       = 3,
    parameter int              NB       = 4,
    parameter int              AW       = 16,
    parameter int              BANK_LSB = 4,
    parameter xbar_pkg::map_e  MAP      = xbar_pkg::MAP_LOW,
    parameter int              WR_LAT   = 2,
    parameter int              RD_LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    p_valid,
    input  logic [NP-1:0]    p_we,
    input  logic [NP*AW-1:0] p_addr,
    output logic [NP-1:0]    p_ready,
    output logic [NP-1:0]    p_wr_ack,
    output logic [NP-1:0]    p_rd_ack,
    output logic [NB-1:0]    b_valid,
    output logic [NB-1:0]    b_we,
    output logic [NB*AW-1:0] b_addr,
    input  logic [NB-1:0]    b_ready,
    input  logic [NB-1:0]    b_lock,
    input  logic [NB-1:0]    b_wr_ack,
    input  logic [NB-1:0]    b_rd_ack
);
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1;
    localparam int IDX_W  = (NP > 1) ? $clog2(NP) : 1;

    logic [NP*BANK_W-1:0]       bank_idx;
    logic [NB-1:0][NP-1:0]      elig;
    logic [NB-1:0][NP-1:0]      held;
    logic [NB-1:0][IDX_W-1:0]   grant;
    logic [NB*IDX_W-1:0]        grant_all;
    logic [NP-1:0]              wr_vec, rd_vec;

    xbar_bank_decode #(
        .NP(NP), .AW(AW), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB), .MAP(MAP)
    ) u_dec (
        .addr(p_addr), .bank_idx(bank_idx)
    );

    // Ports pinned by a locked bank.
    always_comb begin
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++)
                held[b][p] = b_lock[b] && (int'(grant[b]) == p);
    end

    // Eligibility: valid, bank match, not pinned by another bank.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < NP; p++) begin
                logic pinned;
                pinned = 1'b0;
                for (int c = 0; c < NB; c++)
                    if (c != b && held[c][p]) pinned = 1'b1;
                elig[b][p] = p_valid[p] && !pinned &&
                             (int'(bank_idx[p*BANK_W +: BANK_W]) == b);
            end
        end
    end

    // One arbiter and command mux per bank.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        xbar_rr_arb #(.NP(NP), .IDX_W(IDX_W)) u_arb (
            .clk(clk), .rst_n(rst_n), .elig(elig[b]), .lock(b_lock[b]),
            .grant(grant[b]), .active(b_valid[b])
        );
        assign b_we[b]              = p_we[grant[b]];
        assign b_addr[b*AW +: AW]   = p_addr[int'(grant[b])*AW +: AW];
        assign grant_all[b*IDX_W +: IDX_W] = grant[b];
    end

    // Port ready comes from the bank carrying its command.
    always_comb begin
        p_ready = '0;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++)
                if (b_valid[b] && int'(grant[b]) == p && b_ready[b]) p_ready[p] = 1'b1;
    end

    // Turn bank ack pulses into per-port one-hot vectors.
    always_comb begin
        wr_vec = '0;
        rd_vec = '0;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++) begin
                if (b_wr_ack[b] && int'(grant[b]) == p) wr_vec[p] = 1'b1;
                if (b_rd_ack[b] && int'(grant[b]) == p) rd_vec[p] = 1'b1;
            end
    end

    xbar_ack_delay #(.W(NP), .LAT(WR_LAT)) u_wr_dly (
        .clk(clk), .rst_n(rst_n), .din(wr_vec), .dout(p_wr_ack)
    );
    xbar_ack_delay #(.W(NP), .LAT(RD_LAT)) u_rd_dly (
        .clk(clk), .rst_n(rst_n), .din(rd_vec), .dout(p_rd_ack)
    );
endmodule

// File: rtl/xbar_props.sv
// Property checker for bank_lock_xbar, attached by bind.
// Observes ports plus the per-bank grant registers.
module xbar_props #(
    parameter int              NP       = 3,
    parameter int              NB       = 4,
    parameter int              AW       = 16,
    parameter int              BANK_LSB = 4,
    parameter xbar_pkg::map_e  MAP      = xbar_pkg::MAP_LOW,
    parameter int              WR_LAT   = 2,
    parameter int              RD_LAT   = 3,
    parameter int              BANK_W   = 2,
    parameter int              IDX_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NP-1:0]       p_valid,
    input logic [NP-1:0]       p_ready,
    input logic [NP-1:0]       p_wr_ack,
    input logic [NP-1:0]       p_rd_ack,
    input logic [NB-1:0]       b_valid,
    input logic [NB*AW-1:0]    b_addr,
    input logic [NB-1:0]       b_lock,
    input logic [NB*IDX_W-1:0] grant_all
);
    logic [15:0] since_rst;

    // Count cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst != 16'hFFFF) since_rst <= since_rst + 16'd1;
    end

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ready & ~p_valid) == '0); // R7

    AST_WR_ACK_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(since_rst) < WR_LAT) |-> (p_wr_ack == '0)); // R8

    AST_RD_ACK_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(since_rst) < RD_LAT) |-> (p_rd_ack == '0)); // R9

    for (genvar b = 0; b < NB; b++) begin : g_b
        AST_BANK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
            b_valid[b] |-> (xbar_pkg::bank_field(64'(b_addr[b*AW +: AW]), AW, BANK_W,
                                                 BANK_LSB, MAP) == b)); // R1

        AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            b_lock[b] |=> $stable(grant_all[b*IDX_W +: IDX_W])); // R5

        for (genvar c = 0; c < NB; c++) begin : g_c
            if (c != b) begin : g_pair
                AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                    !(b_lock[b] && b_valid[c] &&
                      grant_all[b*IDX_W +: IDX_W] == grant_all[c*IDX_W +: IDX_W])); // R3
            end
        end
    end
endmodule

bind bank_lock_xbar xbar_props #(
    .NP(NP), .NB(NB), .AW(AW), .BANK_LSB(BANK_LSB), .MAP(MAP),
    .WR_LAT(WR_LAT), .RD_LAT(RD_LAT), .BANK_W(BANK_W), .IDX_W(IDX_W)
) u_props (
    .clk(clk), .rst_n(rst_n), .p_valid(p_valid), .p_ready(p_ready),
    .p_wr_ack(p_wr_ack), .p_rd_ack(p_rd_ack), .b_valid(b_valid),
    .b_addr(b_addr), .b_lock(b_lock), .grant_all(grant_all)
);

// File: tb/bank_lock_xbar_tb.sv
// Self-checking bench: a vector table walked cycle by cycle, then directed
// tests for acknowledgement latency and reset.
module bank_lock_xbar_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3, NB = 4, AW = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic [NP-1:0] p_valid, p_we, p_ready, p_wr_ack, p_rd_ack;
    logic [NP*AW-1:0] p_addr;
    logic [NB-1:0] b_valid, b_we, b_ready, b_lock, b_wr_ack, b_rd_ack;
    logic [NB*AW-1:0] b_addr;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_lock_xbar u_dut (
        .clk(clk), .rst_n(rst_n), .p_valid(p_valid), .p_we(p_we), .p_addr(p_addr),
        .p_ready(p_ready), .p_wr_ack(p_wr_ack), .p_rd_ack(p_rd_ack),
        .b_valid(b_valid), .b_we(b_we), .b_addr(b_addr), .b_ready(b_ready),
        .b_lock(b_lock), .b_wr_ack(b_wr_ack), .b_rd_ack(b_rd_ack)
    );

    // Fields: pvalid[3] bank2[2] bank1[2] bank0[2] lock[4] ready[4] exp_bvalid[4] exp_pready[3] exp_bwe[4]
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {3'b001, 2'd0, 2'd0, 2'd0, 4'h0, 4'hF, 4'b0001, 3'b001, 4'b0000},
        {3'b111, 2'd0, 2'd0, 2'd0, 4'h0, 4'hF, 4'b0001, 3'b001, 4'b0000},
        {3'b111, 2'd0, 2'd0, 2'd0, 4'h0, 4'hF, 4'b0001, 3'b010, 4'b0001},
        {3'b111, 2'd0, 2'd0, 2'd0, 4'h0, 4'hF, 4'b0001, 3'b100, 4'b0000},
        {3'b110, 2'd0, 2'd0, 2'd0, 4'h0, 4'hF, 4'b0000, 3'b000, 4'b0000},
        {3'b110, 2'd0, 2'd0, 2'd0, 4'h0, 4'hF, 4'b0001, 3'b010, 4'b0001},
        {3'b111, 2'd3, 2'd2, 2'd1, 4'h0, 4'hF, 4'b0010, 3'b001, 4'b0000},
        {3'b111, 2'd3, 2'd2, 2'd1, 4'h0, 4'hF, 4'b1110, 3'b111, 4'b0100},
        {3'b111, 2'd3, 2'd2, 2'd1, 4'h0, 4'b0100, 4'b1110, 3'b010, 4'b0100},
        {3'b111, 2'd0, 2'd0, 2'd0, 4'b0001, 4'hF, 4'b0001, 3'b100, 4'b0000},
        {3'b111, 2'd0, 2'd0, 2'd0, 4'b0001, 4'hF, 4'b0001, 3'b100, 4'b0000},
        {3'b100, 2'd3, 2'd0, 2'd0, 4'b0001, 4'hF, 4'b0000, 3'b000, 4'b0000},
        {3'b100, 2'd3, 2'd0, 2'd0, 4'h0, 4'hF, 4'b1000, 3'b100, 4'b0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Address with bank field at bits [5:4] and the port number at bits [9:8].
    function automatic logic [AW-1:0] mk_addr(input int port, input logic [1:0] bank);
        return AW'(port << 8) | AW'({bank, 4'h0});
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        p_valid = '0; p_we = 3'b010; p_addr = '0;
        b_ready = '0; b_lock = '0; b_wr_ack = '0; b_rd_ack = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R10 reset b_valid", 32'(b_valid), 32'h0);
        chk("R10 reset p_wr_ack", 32'(p_wr_ack), 32'h0);
        chk("R10 reset p_rd_ack", 32'(p_rd_ack), 32'h0);
        rst_n = 1'b1;

        // Table walk: R2 R4 R6 R7 R3 R5
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            @(negedge clk);
            v = VEC[i];
            p_valid = v[27:25];
            p_addr  = {mk_addr(2, v[24:23]), mk_addr(1, v[22:21]), mk_addr(0, v[20:19])};
            b_lock  = v[18:15];
            b_ready = v[14:11];
            #1;
            chk($sformatf("R2/R4/R6 step %0d b_valid", i), 32'(b_valid), 32'(v[10:7]));
            chk($sformatf("R7 step %0d p_ready", i), 32'(p_ready), 32'(v[6:4]));
            chk($sformatf("R6 step %0d b_we", i), 32'(b_we & b_valid), 32'(v[3:0]));
            if (i == 7)
                chk("R6 bank2 address", 32'(b_addr[2*AW +: AW]), 32'(mk_addr(1, 2'd2)));
            if (i == 11)
                chk("R3 pinned port hidden at bank3", 32'(b_valid[3]), 32'h0);
            if (i == 10)
                chk("R5 locked bank0 still on port2", 32'(b_valid[0] & p_ready[2]), 32'h1);
        end

        // Grants now: bank2 -> port1, bank3 -> port2. Clear requests.
        @(negedge clk);
        p_valid = '0; b_wr_ack = 4'b1000;
        #1 chk("R8 wr ack not immediate", 32'(p_wr_ack), 32'h0);
        @(negedge clk); b_wr_ack = '0;
        #1 chk("R8 wr ack after 1 edge", 32'(p_wr_ack), 32'h0);
        @(negedge clk);
        #1 chk("R8 wr ack after 2 edges", 32'(p_wr_ack), 32'b100);
        @(negedge clk);
        #1 chk("R8 wr ack single pulse", 32'(p_wr_ack), 32'h0);

        @(negedge clk); b_rd_ack = 4'b0100;
        #1 chk("R9 rd ack not immediate", 32'(p_rd_ack), 32'h0);
        @(negedge clk); b_rd_ack = '0;
        #1 chk("R9 rd ack after 1 edge", 32'(p_rd_ack), 32'h0);
        @(negedge clk);
        #1 chk("R9 rd ack after 2 edges", 32'(p_rd_ack), 32'h0);
        @(negedge clk);
        #1 chk("R9 rd ack after 3 edges", 32'(p_rd_ack), 32'b010);
        @(negedge clk);
        #1 chk("R9 rd ack single pulse", 32'(p_rd_ack), 32'h0);

        // R10: reset mid-run returns bank3 to port 0.
        do_reset();
        p_valid = 3'b111;
        p_addr  = {mk_addr(2, 2'd3), mk_addr(1, 2'd3), mk_addr(0, 2'd3)};
        b_ready = 4'hF;
        #1;
        chk("R10 grant at port0 after reset", 32'(p_ready), 32'b001);
        chk("R10 bank3 valid after reset", 32'(b_valid), 32'b1000);
        @(negedge clk);
        #1 chk("R4 rotate to port1 at bank3", 32'(p_ready), 32'b010);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule